// File: doc/BRIEF.md
# Jittered Sampling Switch

This block models the input stage of a protection computing unit as a jittered synchronous task. It repeats one cycle: it latches a one-bit alarm input, spends a processing interval of between `T_MIN` and `T_MAX` ticks, and then drives the latched value onto its output. A new cycle begins on the same tick that the previous one ends. A one-clock tick enable, nominally one millisecond, is the time base. Every count in the block is measured in ticks.

Each cycle takes its length from a 16-bit pseudo-random register, folded into the allowed window. A test port can instead force a fixed length, which is clamped into the same window. Because an input change is only seen at a cycle boundary, a pulse that ends before the next boundary is dropped. The block raises a one-clock flag when a change is lost in this way. Two instances with different bounds model a fast primary unit (27 to 33 ticks) and a slow secondary unit (72 to 81 ticks).

Top module: `jitter_switch`

## Requirements
- R1: While `rst` is high, `alarm_out` and `lost_change` are 0. After reset the block is idle until the first tick with `rst` low, which begins the first cycle and latches `alarm_in`.
- R2: A cycle that begins on a tick latches `alarm_in`. Exactly L ticks later, `alarm_out` takes the latched value, in the clock after that tick. That same tick begins the next cycle. `alarm_out` never changes in a clock that follows a clock with `tick` low.
- R3: While `force_len_en` is 1, each new cycle length L is `force_len` clamped to the range [`T_MIN`, `T_MAX`]. With the defaults, a value of 5 gives 27 and a value of 200 gives 33.
- R4: While `force_len_en` is 0, L is `T_MIN` plus (a 16-bit maximal-length LFSR value modulo (`T_MAX`−`T_MIN`+1)). The LFSR steps once per cycle start, so L always lies in [`T_MIN`, `T_MAX`].
- R5: An input change that is then held steady appears on `alarm_out` no sooner than `T_MIN` ticks and no later than 2·`T_MAX` ticks after it occurs.
- R6: An input pulse longer than `T_MAX` ticks always produces a pulse on `alarm_out`.
- R7: Any high pulse on `alarm_out` lasts at least `T_MIN` ticks.
- R8: `lost_change` pulses high for one clock, in the clock after a cycle-start tick, when the value latched on that tick equals the value latched at the previous cycle start, and `alarm_in` differed from that earlier value in some clock in between. A pulse that is lost in this way never reaches `alarm_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base enable, one clock per tick |
| alarm_in | input | 1 | Alarm input to be latched |
| force_len_en | input | 1 | Selects forced cycle length |
| force_len | input | FORCE_W | Forced cycle length in ticks, clamped |
| alarm_out | output | 1 | Latched alarm after processing |
| lost_change | output | 1 | One-clock flag for a dropped input change |

## Verification
With the cycle length forced, a tick-accurate model in the bench predicts `alarm_out` and `lost_change`. The model is compared against the design at every clock. This holds the design to the rule that the output moves in the clock after the tick that ends a cycle, and that the flag pulses in that same clock. Directed cases align to a cycle boundary and then raise the input. The output is due exactly 2·L·(tick period) clocks later, and the bench counts clocks to that point. With random lengths, the bench cannot predict exact timing, so it measures each output edge in clocks from the input edge against the window [`T_MIN`, 2·`T_MAX`] ticks, and it measures each output pulse width against `T_MIN` ticks.

// File: rtl/jsw_pkg.sv
package jsw_pkg;
   localparam int RND_W = 16;
   localparam logic [RND_W-1:0] RND_TAPS = 16'hB400;
endpackage

// File: rtl/jsw_lfsr.sv
module jsw_lfsr
   import jsw_pkg::*;
#(
   parameter logic [RND_W-1:0] SEED = 16'hACE1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   output logic [RND_W-1:0] value
);
   if (SEED == '0) begin : g_bad_seed
      $error("jsw_lfsr: SEED must be nonzero");
   end

   logic [RND_W-1:0] state_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SEED;
      end else if (step) begin
         state_q <= state_q[0] ? ((state_q >> 1) ^ RND_TAPS) : (state_q >> 1);
      end
   end

   assign value = state_q;

   // R4: the generator never locks up in the all-zero state
   assert_lfsr_live_R4: assert property (@(posedge clk) disable iff (rst)
      state_q != '0);
endmodule

// File: rtl/jsw_len_sel.sv
module jsw_len_sel
   import jsw_pkg::*;
#(
   parameter int T_MIN   = 27,
   parameter int T_MAX   = 33,
   parameter int LEN_W   = 6,
   parameter int FORCE_W = 8
) (
   input  logic [RND_W-1:0]   rnd,
   input  logic               force_en,
   input  logic [FORCE_W-1:0] force_len,
   output logic [LEN_W-1:0]   len
);
   localparam int SPAN = T_MAX - T_MIN + 1;

   logic [LEN_W-1:0] rnd_len;
   logic [LEN_W-1:0] frc_len;

   if (SPAN == 1) begin : g_fixed
      assign rnd_len = LEN_W'(T_MIN);
   end else if ((SPAN & (SPAN - 1)) == 0) begin : g_mask
      localparam int MB = $clog2(SPAN);
      assign rnd_len = LEN_W'(T_MIN) + LEN_W'(rnd[MB-1:0]);
   end else begin : g_mod
      logic [31:0] rem;
      assign rem     = 32'(rnd) % 32'(SPAN);
      assign rnd_len = LEN_W'(32'(T_MIN) + rem);
   end

   always_comb begin
      if (32'(force_len) < 32'(T_MIN)) begin
         frc_len = LEN_W'(T_MIN);
      end else if (32'(force_len) > 32'(T_MAX)) begin
         frc_len = LEN_W'(T_MAX);
      end else begin
         frc_len = LEN_W'(force_len);
      end
   end

   assign len = force_en ? frc_len : rnd_len;
endmodule

// File: rtl/jitter_switch.sv
module jitter_switch
   import jsw_pkg::*;
#(
   parameter int               T_MIN     = 27,
   parameter int               T_MAX     = 33,
   parameter int               FORCE_W   = 8,
   parameter logic [RND_W-1:0] LFSR_SEED = 16'hACE1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               tick,
   input  logic               alarm_in,
   input  logic               force_len_en,
   input  logic [FORCE_W-1:0] force_len,
   output logic               alarm_out,
   output logic               lost_change
);
   localparam int LEN_W = $clog2(T_MAX + 1);

   if (T_MIN < 1) begin : g_bad_min
      $error("jitter_switch: T_MIN must be at least 1");
   end
   if (T_MAX < T_MIN) begin : g_bad_max
      $error("jitter_switch: T_MAX must not be below T_MIN");
   end

   logic             running_q;
   logic [LEN_W-1:0] remain_q;
   logic             latched_q;
   logic             disturbed_q;
   logic             out_q;
   logic             lost_q;
   logic [RND_W-1:0] rnd_val;
   logic [LEN_W-1:0] next_len;
   logic             cycle_end;
   logic             cycle_start;

   assign cycle_end   = tick && running_q && (remain_q == '0);
   assign cycle_start = tick && (!running_q || (remain_q == '0));

   jsw_lfsr #(.SEED(LFSR_SEED)) u_rnd (
      .clk   (clk),
      .rst   (rst),
      .step  (cycle_start),
      .value (rnd_val)
   );

   jsw_len_sel #(
      .T_MIN   (T_MIN),
      .T_MAX   (T_MAX),
      .LEN_W   (LEN_W),
      .FORCE_W (FORCE_W)
   ) u_len (
      .rnd       (rnd_val),
      .force_en  (force_len_en),
      .force_len (force_len),
      .len       (next_len)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         running_q   <= 1'b0;
         remain_q    <= '0;
         latched_q   <= 1'b0;
         disturbed_q <= 1'b0;
         out_q       <= 1'b0;
         lost_q      <= 1'b0;
      end else begin
         lost_q <= 1'b0;
         if (cycle_start) begin
            running_q   <= 1'b1;
            latched_q   <= alarm_in;
            remain_q    <= next_len - LEN_W'(1);
            disturbed_q <= 1'b0;
            if (cycle_end) begin
               out_q  <= latched_q;
               lost_q <= disturbed_q && (alarm_in == latched_q);
            end
         end else begin
            if (tick && running_q) begin
               remain_q <= remain_q - LEN_W'(1);
            end
            if (running_q && (alarm_in != latched_q)) begin
               disturbed_q <= 1'b1;
            end
         end
      end
   end

   assign alarm_out   = out_q;
   assign lost_change = lost_q;

   // R1: outputs are cleared in the clock after reset is sampled
   assert_reset_clear_R1: assert property (@(posedge clk)
      $past(rst) |-> (!alarm_out && !lost_change));

   // R2: the output only moves on the clock after a tick
   assert_out_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(alarm_out));

   // R2: the countdown never exceeds the longest cycle
   assert_remain_bound_R2: assert property (@(posedge clk) disable iff (rst)
      remain_q < LEN_W'(T_MAX));

   // R3 R4: every chosen length lies inside the window
   assert_len_window_R4: assert property (@(posedge clk) disable iff (rst)
      cycle_start |-> ((next_len >= LEN_W'(T_MIN)) && (next_len <= LEN_W'(T_MAX))));

   // R8: the lost flag is a single-clock pulse following a tick
   assert_lost_single_R8: assert property (@(posedge clk) disable iff (rst)
      lost_change |=> !lost_change);

   assert_lost_after_tick_R8: assert property (@(posedge clk) disable iff (rst)
      lost_change |-> $past(tick));
endmodule

// File: tb/jitter_switch_tb.sv
`timescale 1ns/1ps
module jitter_switch_tb;
   localparam int TMIN = 27;
   localparam int TMAX = 33;
   localparam int TP   = 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick = 1'b0;
   logic       alarm = 1'b0;
   logic       fen = 1'b0;
   logic [7:0] flen = 8'd30;
   logic       out_w;
   logic       lost_w;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   jitter_switch u_dut (
      .clk          (clk),
      .rst          (rst),
      .tick         (tick),
      .alarm_in     (alarm),
      .force_len_en (fen),
      .force_len    (flen),
      .alarm_out    (out_w),
      .lost_change  (lost_w)
   );

   always #10 clk = ~clk;

   initial begin
      int tdiv = 0;
      forever begin
         @(negedge clk);
         tdiv = (tdiv + 1) % TP;
         tick = (tdiv == 0);
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int clamp_len(input int v);
      if (v < TMIN) return TMIN;
      if (v > TMAX) return TMAX;
      return v;
   endfunction

   // tick-level model of the forced-length behaviour
   bit model_on = 1'b0;
   bit m_run = 0, m_held = 0, m_dirty = 0, m_out = 0, m_lost = 0, m_bnd = 0;
   int m_cnt = 0;

   always @(posedge clk) begin
      m_lost = 1'b0;
      m_bnd  = 1'b0;
      if (rst) begin
         m_run = 0; m_held = 0; m_dirty = 0; m_out = 0; m_cnt = 0;
      end else if (tick && (!m_run || m_cnt == 0)) begin
         if (m_run) begin
            m_lost = m_dirty && (alarm == m_held);
            m_out  = m_held;
         end
         m_bnd   = 1'b1;
         m_run   = 1'b1;
         m_held  = alarm;
         m_dirty = 1'b0;
         m_cnt   = clamp_len(int'(flen)) - 1;
      end else begin
         if (tick && m_run) m_cnt--;
         if (m_run && alarm != m_held) m_dirty = 1'b1;
      end
   end

   always @(negedge clk) begin
      if (model_on && !rst) begin
         chk(out_w == m_out, "R2 R3 alarm_out", int'(out_w), int'(m_out));
         chk(lost_w == m_lost, "R8 lost_change", int'(lost_w), int'(m_lost));
      end
   end

   task automatic wait_bnd();
      do @(negedge clk); while (!m_bnd);
   endtask

   // boundary-aligned rise: output is due 2*L ticks later
   task automatic aligned_rise(input int fl);
      int k;
      flen = 8'(fl);
      wait_bnd();
      wait_bnd();
      alarm = 1'b1;
      k = 0;
      while (!out_w && k < 4 * TMAX * TP) begin
         @(negedge clk);
         k++;
      end
      chk(k == 2 * clamp_len(fl) * TP, "R3 aligned rise delay", k, 2 * clamp_len(fl) * TP);
      alarm = 1'b0;
      repeat (3 * TMAX * TP) @(negedge clk);
   endtask

   // free-running pulse with random lengths
   task automatic free_pulse(input int w_clk, input bit is_long);
      int rise_k = -1;
      int fall_k = -1;
      for (int k = 0; k < w_clk + 3 * TMAX * TP; k++) begin
         alarm = (k < w_clk);
         @(negedge clk);
         if (out_w && rise_k < 0) rise_k = k + 1;
         if (!out_w && rise_k >= 0 && fall_k < 0) fall_k = k + 1;
      end
      alarm = 1'b0;
      if (is_long) begin
         chk(rise_k >= 0, "R6 long pulse appears", rise_k, 1);
         chk(rise_k >= TMIN * TP && rise_k <= 2 * TMAX * TP, "R4 R5 rise delay",
             rise_k, TMIN * TP);
      end
      if (rise_k >= 0 && fall_k >= 0) begin
         chk(fall_k - rise_k >= TMIN * TP, "R7 output width", fall_k - rise_k, TMIN * TP);
      end
   endtask

   initial begin
      void'($urandom(32'd2024));
      fen   = 1'b1;
      flen  = 8'd30;
      alarm = 1'b1;
      repeat (5) @(negedge clk);
      chk(out_w == 1'b0 && lost_w == 1'b0, "R1 outputs in reset", int'(out_w), 0);
      rst = 1'b0;
      @(negedge clk);
      chk(out_w == 1'b0 && lost_w == 1'b0, "R1 outputs after reset", int'(out_w), 0);
      model_on = 1'b1;
      begin
         int k = 0;
         while (!out_w && k < 3 * TMAX * TP) begin
            @(negedge clk);
            k++;
         end
         chk(out_w == 1'b1 && k <= 31 * TP, "R1 first cycle latches input", k, 30 * TP);
      end
      alarm = 1'b0;
      repeat (3 * TMAX * TP) @(negedge clk);

      // R8: short pulse fully inside one cycle is lost and flagged
      begin
         int nlost = 0;
         int nhigh = 0;
         flen = 8'd30;
         wait_bnd();
         wait_bnd();
         repeat (2 * TP) @(negedge clk);
         alarm = 1'b1;
         repeat (2 * TP) @(negedge clk);
         alarm = 1'b0;
         repeat (32 * TP) begin
            @(negedge clk);
            if (lost_w) nlost++;
            if (out_w) nhigh++;
         end
         chk(nlost == 1, "R8 lost pulse count", nlost, 1);
         chk(nhigh == 0, "R8 lost pulse kept off output", nhigh, 0);
      end

      aligned_rise(5);
      aligned_rise(200);
      aligned_rise(29);

      for (int i = 0; i < 40; i++) begin
         flen = 8'($urandom_range(0, 255));
         repeat ($urandom_range(0, 100) * TP) @(negedge clk);
         alarm = 1'b1;
         repeat ($urandom_range(1, 80) * TP + $urandom_range(0, 3)) @(negedge clk);
         alarm = 1'b0;
      end
      repeat (3 * TMAX * TP) @(negedge clk);

      model_on = 1'b0;
      fen = 1'b0;
      repeat (3 * TMAX * TP) @(negedge clk);
      chk(out_w == 1'b0, "R2 output settled low", int'(out_w), 0);
      for (int i = 0; i < 30; i++) begin
         if (i % 2 == 0) begin
            free_pulse(($urandom_range(TMAX + 1, TMAX + 30)) * TP + 1, 1'b1);
         end else begin
            free_pulse($urandom_range(1, TMAX * TP), 1'b0);
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule